// File: doc/BRIEF.md
# Shared FM0 / Manchester Line Encoder

This block turns a serial stream of data bits into a DC-balanced two-level line waveform for a short-range roadside radio transmitter. A mode input selects FM0 or Manchester coding. Both codes run through one level register and one next-level function, so every gate and flop is in use in either mode.

Each bit period is cut into two half-bit slots. A clock enable running at twice the bit rate marks the slots. A bit strobe, raised together with that enable, marks the first slot of each bit and is the moment when the data bit and the code choice are captured. The output is a register that moves only on enabled cycles, so the block runs on one free-running clock. A clear input returns the encoder to its idle, low state. Clear is a separate control from the mode select, so a change of code never resets the encoder.

Top module: `fm0man_enc`

## Requirements
- R1: After reset, and in the cycle after any cycle with `clr` high, `line_out` is 0 and the stored level is 0. `clr` takes priority over a bit strobe in the same cycle.
- R2: In Manchester mode (`mode_man`=1) the first half-bit slot carries the inverse of the data bit and the second slot carries the data bit. This is the data bit XORed with a bit clock that is high in the first half.
- R3: In FM0 mode (`mode_man`=0) the output level at the start of every bit is the inverse of the level just before it. After a clear, the first FM0 bit therefore starts high.
- R4: In FM0 mode the second slot holds the first-slot level when the data bit is 1, and inverts it when the data bit is 0.
- R5: `line_out` changes only in the cycle after a cycle with `half_en` high. It is stable across cycles where `half_en` is low.
- R6: The code is sampled only at the bit strobe. A change of `mode_man` during the second slot does not alter that bit's encoding.
- R7: The data bit is sampled only at the bit strobe. A change of `data_in` during the second slot does not alter that bit's encoding.
- R8: When no bit is in progress, an enable without a bit strobe leaves `line_out` unchanged. Encoding starts only at the next strobe.
- R9: Toggling `mode_man` while `clr` is low never changes `line_out` or the stored level on its own.
- R10: Every Manchester bit has exactly one high and one low half-bit slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous encoder clear, separate from the mode select |
| half_en | input | 1 | Clock enable at twice the bit rate; one pulse per half-bit slot |
| bit_stb | input | 1 | Bit strobe, high with `half_en` on the first slot of each bit |
| data_in | input | 1 | Data bit, sampled at the bit strobe |
| mode_man | input | 1 | Code select: 1 = Manchester, 0 = FM0; sampled at the bit strobe |
| line_out | output | 1 | Registered encoded line level |

## Verification
The hardest condition to reach from the ports is a code or data change that lands inside a bit that is already half sent. The encoding must come from the values captured at the strobe and not from the live inputs.

The stimulus drives the second half-bit slot with the data input inverted in every vector. Directed bits switch the mode select in the middle of a bit, in both directions. The data values are chosen so that a leak of the live inputs would change the second-slot level.

Further directed steps cover three cases:
- a clear that arrives in the same cycle as a strobe;
- bare enables while the encoder is idle;
- mode toggles with no enable at all.

// File: rtl/fm0man_pkg.sv
package fm0man_pkg;

    localparam int HALVES_PER_BIT = 2;
    localparam int PH_W           = $clog2(HALVES_PER_BIT);

    typedef enum logic {
        CODE_FM0 = 1'b0,
        CODE_MAN = 1'b1
    } code_e;

    typedef struct packed {
        logic  data;
        code_e code;
    } bitctx_t;

    // One function serves both codes: a base level XORed with a flip term.
    function automatic logic next_level(code_e code, logic data, logic lvl, logic first);
        logic base;
        logic flip;
        base = (code == CODE_MAN) ? data  : lvl;
        flip = (code == CODE_MAN) ? first : (first | ~data);
        return base ^ flip;
    endfunction

endpackage

// File: rtl/fm0man_slot_seq.sv
module fm0man_slot_seq
    import fm0man_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic half_en,
    input  logic bit_stb,
    output logic slot_fire,
    output logic slot_first,
    output logic busy
);
    logic [PH_W-1:0] ph_q;

    assign busy       = (ph_q != '0);
    assign slot_first = half_en & bit_stb;
    assign slot_fire  = half_en & (bit_stb | busy);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ph_q <= '0;
        end else if (slot_first) begin
            ph_q <= PH_W'(1);
        end else if (slot_fire) begin
            if (ph_q == PH_W'(HALVES_PER_BIT - 1))
                ph_q <= '0;
            else
                ph_q <= ph_q + PH_W'(1);
        end
    end
endmodule

// File: rtl/fm0man_ctx_latch.sv
module fm0man_ctx_latch
    import fm0man_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    slot_first,
    input  bitctx_t live_ctx,
    output bitctx_t held_ctx,
    output bitctx_t use_ctx
);
    bitctx_t ctx_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            ctx_q <= '{data: 1'b0, code: CODE_FM0};
        else if (slot_first)
            ctx_q <= live_ctx;
    end

    assign held_ctx = ctx_q;
    assign use_ctx  = slot_first ? live_ctx : ctx_q;
endmodule

// File: rtl/fm0man_level_core.sv
module fm0man_level_core
    import fm0man_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    slot_fire,
    input  logic    slot_first,
    input  bitctx_t use_ctx,
    output logic    level
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            lvl_q <= 1'b0;
        else if (slot_fire)
            lvl_q <= next_level(use_ctx.code, use_ctx.data, lvl_q, slot_first);
    end

    assign level = lvl_q;
endmodule

// File: rtl/fm0man_enc.sv
module fm0man_enc
    import fm0man_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic half_en,
    input  logic bit_stb,
    input  logic data_in,
    input  logic mode_man,
    output logic line_out
);
    logic    slot_fire;
    logic    slot_first;
    logic    busy;
    bitctx_t live_ctx;
    bitctx_t held_ctx;
    bitctx_t use_ctx;

    assign live_ctx.data = data_in;
    assign live_ctx.code = mode_man ? CODE_MAN : CODE_FM0;

    fm0man_slot_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .half_en    (half_en),
        .bit_stb    (bit_stb),
        .slot_fire  (slot_fire),
        .slot_first (slot_first),
        .busy       (busy)
    );

    fm0man_ctx_latch u_ctx (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .slot_first (slot_first),
        .live_ctx   (live_ctx),
        .held_ctx   (held_ctx),
        .use_ctx    (use_ctx)
    );

    fm0man_level_core u_core (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .slot_fire  (slot_fire),
        .slot_first (slot_first),
        .use_ctx    (use_ctx),
        .level      (line_out)
    );
endmodule

// File: rtl/fm0man_chk.sv
module fm0man_chk
    import fm0man_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    clr,
    input logic    half_en,
    input logic    bit_stb,
    input logic    mode_man,
    input logic    line_out,
    input logic    slot_fire,
    input logic    slot_first,
    input bitctx_t held_ctx
);
    // R1
    assert_clear_low_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> !line_out);

    // R5
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!half_en && !clr) |=> $stable(line_out));

    // R3
    assert_fm0_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (half_en && bit_stb && !clr && !mode_man) |=> (line_out != $past(line_out)));

    // R4
    assert_fm0_one_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (slot_fire && !slot_first && !clr && held_ctx.code == CODE_FM0 && held_ctx.data)
        |=> $stable(line_out));

    // R10
    assert_man_mid_R10: assert property (@(posedge clk) disable iff (rst)
        (slot_fire && !slot_first && !clr && held_ctx.code == CODE_MAN)
        |=> (line_out != $past(line_out)));
endmodule

bind fm0man_enc fm0man_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .half_en    (half_en),
    .bit_stb    (bit_stb),
    .mode_man   (mode_man),
    .line_out   (line_out),
    .slot_fire  (slot_fire),
    .slot_first (slot_first),
    .held_ctx   (held_ctx)
);

// File: tb/tb_fm0man_enc.sv
module tb_fm0man_enc;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    // {mode_man, data, expected first slot, expected second slot}, sent after a clear
    localparam logic [3:0] VEC [0:9] = '{
        4'b0111, 4'b0001, 4'b0001, 4'b0100, 4'b1101,
        4'b1010, 4'b0111, 4'b0001, 4'b1010, 4'b1101
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic half_en = 1'b0;
    logic bit_stb = 1'b0;
    logic data_in = 1'b0;
    logic mode_man = 1'b0;
    logic line_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    fm0man_enc dut (
        .clk(clk), .rst(rst), .clr(clr), .half_en(half_en), .bit_stb(bit_stb),
        .data_in(data_in), .mode_man(mode_man), .line_out(line_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    // Sends one bit; the second-slot mode and data may differ to probe sampling.
    task automatic send_bit(input logic m, input logic d, input logic m2, input logic d2,
                            output logic h1, output logic h2);
        @(negedge clk);
        half_en = 1'b1; bit_stb = 1'b1; mode_man = m; data_in = d;
        @(negedge clk);
        h1 = line_out;
        half_en = 1'b1; bit_stb = 1'b0; mode_man = m2; data_in = d2;
        @(negedge clk);
        h2 = line_out;
        half_en = 1'b0;
    endtask

    initial begin
        logic h1, h2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset level", line_out, 1'b0);

        // R8: bare enables while idle
        half_en = 1'b1; bit_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 idle enable", line_out, 1'b0);
        half_en = 1'b0;

        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;

        for (int i = 0; i < 10; i++) begin
            logic m, d;
            m = VEC[i][3];
            d = VEC[i][2];
            send_bit(m, d, m, ~d, h1, h2);
            if (m) begin
                check("R2 manchester first slot", h1, VEC[i][1]);
                check("R2 manchester second slot", h2, VEC[i][0]);
                check("R2 manchester decode", h2, d);
                check("R10 manchester balance", h1 ^ h2, 1'b1);
            end else begin
                check("R3 fm0 bit-start level", h1, VEC[i][1]);
                check("R4 fm0 mid-bit level", h2, VEC[i][0]);
                check("R4 fm0 decode", (h1 == h2), d);
            end
            check("R7 data change in second slot", h2, VEC[i][0]);
        end

        // Level is now 1. R6: FM0 bit, switch to Manchester mid-bit.
        send_bit(1'b0, 1'b1, 1'b1, 1'b1, h1, h2);
        check("R6 fm0 first slot", h1, 1'b0);
        check("R6 fm0 kept after mid-bit mode change", h2, 1'b0);

        // Level 0. R6: Manchester bit, switch to FM0 mid-bit.
        send_bit(1'b1, 1'b0, 1'b0, 1'b1, h1, h2);
        check("R6 manchester first slot", h1, 1'b1);
        check("R6 manchester kept after mid-bit mode change", h2, 1'b0);

        // Level 0 -> FM0 data 1 gives 1,1.
        send_bit(1'b0, 1'b1, 1'b0, 1'b1, h1, h2);
        check("R3 fm0 start high", h1, 1'b1);
        check("R4 fm0 hold on one", h2, 1'b1);

        // R9 and R5: mode toggles with no enable.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mode_man = ~mode_man;
        end
        @(negedge clk);
        check("R9 mode toggle keeps output", line_out, 1'b1);
        check("R5 stable without enable", line_out, h2);

        // R8: bare enables after a completed bit.
        half_en = 1'b1; bit_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 enable without strobe", line_out, 1'b1);

        // R1: clear together with a strobe wins.
        clr = 1'b1; bit_stb = 1'b1; mode_man = 1'b0; data_in = 1'b1;
        @(negedge clk);
        check("R1 clear beats strobe", line_out, 1'b0);
        clr = 1'b0; half_en = 1'b0; bit_stb = 1'b0;
        @(negedge clk);
        check("R1 low after clear", line_out, 1'b0);

        send_bit(1'b0, 1'b0, 1'b0, 1'b0, h1, h2);
        check("R3 first bit after clear", h1, 1'b1);
        check("R4 fm0 invert on zero", h2, 1'b0);

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule